// File: doc/BRIEF.md
# Preloaded Four-Channel PWM Timer

This block is a 12-bit up-counter that drives four pulse-width-modulated outputs. The counter starts at zero after reset and counts up to its all-ones value. At that value it wraps back to a programmable reload value, not to zero. The length of each PWM period is therefore 4096 minus the reload value. For example, a reload value of 3584 on an 8 MHz counter clock gives a 512-cycle period, which is 15.625 kHz.

Each channel compares the counter with its active duty value. The channel's raw level is high while the counter is below that value. A per-channel polarity bit inverts the level. A per-channel enable forces the output to its inactive level, which is the polarity bit, while the channel is disabled.

Software writes duty values and polarity bits into preload registers. These values move into the active registers only at a counter wrap, and only if a transfer-arm bit is set. The arm bit clears itself once that copy has been made. A one-cycle interrupt strobe marks every wrap while it is enabled.

Top module: `pwm4_reload_timer`

## Requirements
- R1: During synchronous active-low reset and after it, the counter, the reload value, all preload and active registers and all control bits are zero. All four outputs are low and `irq_pulse` is low.
- R2: After reset the counter starts at 0 and rises by one each cycle. The cycle in which it holds 4095 is the wrap cycle. On the next edge it loads the reload value (address 0). The first wrap cycle therefore comes 4095 cycles after reset is released.
- R3: Outside the first period, wraps occur every 4096 − reload cycles. A reload of 3584 gives 512 cycles and a reload of 4000 gives 96 cycles. A new reload value is used from the next wrap onward.
- R4: A channel's raw level is high exactly while the counter is below its active duty value. It therefore goes high after a wrap and low at the duty match. When the active duty is not above the reload value, the channel never pulses.
- R5: Writes to the duty preload registers (address 2 + channel) and to the polarity field (control bits 11:8, one bit per channel, bit 8 for channel 0) do not change any output until a wrap that finds the arm bit set.
- R6: The arm bit is control bit 1. Every control write sets it to the written value. At a wrap where it is set, the preload duties and polarities are copied to the active registers and the bit clears. A later wrap with no new arm copies nothing.
- R7: When a channel's active polarity bit is 1, its output is the inverse of its raw level.
- R8: Output enables are control bits 7:4 (bit 4 for channel 0) and take effect on the cycle after the write. A disabled output sits at its active polarity level.
- R9: `irq_pulse` is high exactly in wrap cycles while control bit 0 is set, and stays low while that bit is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 reload, 1 control, 2..5 duty preload of channels 0..3 |
| wr_data | input | 12 | Write data |
| irq_pulse | output | 1 | One-cycle strobe on each wrap while the interrupt is enabled |
| pwm_out | output | 4 | PWM outputs, bit n for channel n |

## Verification
A stale or wrongly copied active register shows up as a pulse width that is off across a whole period. It appears within one period of the wrap that should have copied, or should not have copied, the preload. A wrong counter value corrupts both the wrap strobe and every channel edge in the same cycle. The cycle-by-cycle comparison therefore flags it at once, while the per-period width and period counts name the requirement involved. An arm bit that fails to clear becomes visible only after a second wrap, so that sequence is driven on purpose.

// File: rtl/ptmr_pkg.sv
`timescale 1ns/1ps
// Shared register addresses and control-field positions for the preloaded PWM timer.
// Assumes the write data is wide enough to hold the polarity field (CTRL_POL_LSB + channels).
package ptmr_pkg;
    typedef enum logic [2:0] {
        REG_RELOAD = 3'd0,
        REG_CTRL   = 3'd1,
        REG_DUTY0  = 3'd2
    } ptmr_addr_e;

    localparam int CTRL_IRQ_BIT = 0;
    localparam int CTRL_ARM_BIT = 1;
    localparam int CTRL_OE_LSB  = 4;
    localparam int CTRL_POL_LSB = 8;
endpackage

// File: rtl/ptmr_counter.sv
`timescale 1ns/1ps
// Free-running up-counter that wraps from all-ones to a reload value.
// Assumes reload_val is stable around the wrap edge; wrap is high in the all-ones cycle.
module ptmr_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assign wrap = (cnt == CNT_MAX);

    // Count up; on the all-ones value load the reload value instead of zero.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wrap) cnt <= reload_val;
        else           cnt <= cnt + 1'b1;
    end

    // R2
    cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX) |=> (cnt == $past(reload_val)));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/ptmr_regs.sv
`timescale 1ns/1ps
// Register file: reload value, control bits, duty/polarity preloads and active copies.
// Assumes one write per cycle; a control write in a wrap cycle sets the arm bit to the
// written value, while the copy at that wrap uses the values held before the write.
module ptmr_regs
    import ptmr_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int NCH    = 4,
    parameter int ADDR_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [CNT_W-1:0]          wr_data,
    input  logic                      wrap,
    output logic [CNT_W-1:0]          reload_val,
    output logic                      irq_en,
    output logic [NCH-1:0]            oe,
    output logic [NCH-1:0]            pol_act,
    output logic [NCH-1:0][CNT_W-1:0] duty_act
);
    logic                      arm;
    logic [NCH-1:0]            pol_pre;
    logic [NCH-1:0][CNT_W-1:0] duty_pre;
    logic                      reload_wr;
    logic                      ctrl_wr;

    assign reload_wr = wr_en && (int'(wr_addr) == int'(REG_RELOAD));
    assign ctrl_wr   = wr_en && (int'(wr_addr) == int'(REG_CTRL));

    // Hold the reload value written at its address.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_val <= '0;
        else if (reload_wr) reload_val <= wr_data;
    end

    // Hold the control fields; the arm bit also clears itself at a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en  <= 1'b0;
            arm     <= 1'b0;
            oe      <= '0;
            pol_pre <= '0;
        end else if (ctrl_wr) begin
            irq_en  <= wr_data[CTRL_IRQ_BIT];
            arm     <= wr_data[CTRL_ARM_BIT];
            oe      <= wr_data[CTRL_OE_LSB +: NCH];
            pol_pre <= wr_data[CTRL_POL_LSB +: NCH];
        end else if (wrap) begin
            arm     <= 1'b0;
        end
    end

    // Capture duty preloads, one address per channel after the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_pre <= '0;
        end else begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (wr_en && (int'(wr_addr) == int'(REG_DUTY0) + ch))
                    duty_pre[ch] <= wr_data;
            end
        end
    end

    // Copy preloads into the active registers at an armed wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_act <= '0;
            pol_act  <= '0;
        end else if (wrap && arm) begin
            duty_act <= duty_pre;
            pol_act  <= pol_pre;
        end
    end

    // R6
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && arm && !ctrl_wr) |=> !arm);

    // R5
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(duty_act) && $stable(pol_act)));
endmodule

// File: rtl/ptmr_channel.sv
`timescale 1ns/1ps
// One PWM channel: raw level high while the counter is below the active duty value,
// then gated by the enable and inverted by the polarity bit (disabled = polarity level).
module ptmr_channel #(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty,
    input  logic             pol,
    input  logic             oe,
    output logic             out
);
    logic raw;

    // Form the raw level, apply the enable, then the polarity.
    always_comb begin
        raw = (cnt < duty);
        out = (oe & raw) ^ pol;
    end
endmodule

// File: rtl/pwm4_reload_timer.sv
`timescale 1ns/1ps
// Preloaded multi-channel PWM timer: reload counter, register file and NCH channels.
// Assumes CTRL_POL_LSB + NCH <= CNT_W so the control fields fit in one write word.
module pwm4_reload_timer
    import ptmr_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int NCH    = 4,
    parameter int ADDR_W = $clog2(NCH + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              irq_pulse,
    output logic [NCH-1:0]    pwm_out
);
    logic [CNT_W-1:0]          cnt;
    logic                      wrap;
    logic [CNT_W-1:0]          reload_val;
    logic                      irq_en;
    logic [NCH-1:0]            oe;
    logic [NCH-1:0]            pol_act;
    logic [NCH-1:0][CNT_W-1:0] duty_act;

    ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .reload_val(reload_val), .cnt(cnt), .wrap(wrap)
    );

    ptmr_regs #(.CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wrap(wrap), .reload_val(reload_val), .irq_en(irq_en), .oe(oe),
        .pol_act(pol_act), .duty_act(duty_act)
    );

    // Strobe the interrupt in each wrap cycle while enabled.
    assign irq_pulse = irq_en & wrap;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ptmr_channel #(.CNT_W(CNT_W)) u_ch (
            .cnt(cnt), .duty(duty_act[g]), .pol(pol_act[g]), .oe(oe[g]), .out(pwm_out[g])
        );

        // R4
        no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((cnt >= reload_val) && (duty_act[g] <= reload_val)) |-> (pwm_out[g] == pol_act[g]));
    end

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (cnt == '1));
endmodule

// File: tb/pwm4_reload_timer_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every cycle, plus directed
// period, pulse-width and strobe measurements per requirement.
module pwm4_reload_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        irq_pulse;
    logic [3:0]  pwm_out;

    always #2.5 clk = ~clk;

    pwm4_reload_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_pulse(irq_pulse), .pwm_out(pwm_out)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int since_rst = 0;
    int g_gap;
    int g_hi [4];

    task automatic chk_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Reference model state
    int   m_cnt = 0, m_arr = 0;
    int   m_dpre [4];
    int   m_dact [4];
    logic m_irqen = 0, m_arm = 0;
    logic [3:0] m_en = 0, m_ppre = 0, m_pact = 0;
    bit   m_valid = 0;

    always @(posedge clk) begin
        since_rst <= rst_n ? since_rst + 1 : 0;
        if (!rst_n) begin
            m_cnt = 0; m_arr = 0; m_irqen = 0; m_arm = 0;
            m_en = 0; m_ppre = 0; m_pact = 0;
            for (int i = 0; i < 4; i++) begin m_dpre[i] = 0; m_dact[i] = 0; end
            m_valid = 1;
        end else begin
            if (m_cnt == 4095) begin
                if (m_arm) begin
                    for (int i = 0; i < 4; i++) m_dact[i] = m_dpre[i];
                    m_pact = m_ppre;
                    m_arm = 0;
                end
                m_cnt = m_arr;
            end else begin
                m_cnt = m_cnt + 1;
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_arr = int'(wr_data);
                    3'd1: begin
                        m_irqen = wr_data[0];
                        m_arm   = wr_data[1];
                        m_en    = wr_data[7:4];
                        m_ppre  = wr_data[11:8];
                    end
                    3'd2, 3'd3, 3'd4, 3'd5: m_dpre[int'(wr_addr) - 2] = int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    // Cycle-by-cycle comparison against the model (R4 R7 R8 R9)
    always @(negedge clk) begin
        if (m_valid && !finished) begin
            logic [3:0] exp_pwm;
            for (int i = 0; i < 4; i++)
                exp_pwm[i] = (m_en[i] & (m_cnt < m_dact[i])) ^ m_pact[i];
            chk_eq("R4", "model pwm_out", int'(pwm_out), int'(exp_pwm));
            chk_eq("R9", "model irq_pulse", int'(irq_pulse), int'(m_irqen && m_cnt == 4095));
        end
    end

    function automatic logic [11:0] ctrl(bit irq, bit arm, logic [3:0] oe, logic [3:0] pol);
        return {pol, oe, 2'b00, arm, irq};
    endfunction

    task automatic wr(int addr, logic [11:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_irq();
        do @(negedge clk); while (!irq_pulse);
    endtask

    // Starting at a strobe cycle, count cycles and high levels up to the next strobe.
    task automatic measure();
        g_gap = 0;
        for (int i = 0; i < 4; i++) g_hi[i] = 0;
        do begin
            @(negedge clk);
            g_gap++;
            for (int i = 0; i < 4; i++) g_hi[i] += int'(pwm_out[i]);
        end while (!irq_pulse);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk_eq("R1", "pwm_out in reset", int'(pwm_out), 0);
        chk_eq("R1", "irq in reset", int'(irq_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1", "pwm_out after reset", int'(pwm_out), 0);

        wr(0, 12'd3584);
        wr(2, 12'd3840);
        wr(3, 12'd3600);
        wr(4, 12'd3584);
        wr(5, 12'd4000);
        wr(1, ctrl(1, 1, 4'hF, 4'h0));
        wait_irq();
        chk_eq("R2", "cycles from reset to first wrap", since_rst, 4095);
        measure();
        chk_eq("R3", "period with reload 3584", g_gap, 512);
        chk_eq("R4", "ch0 width duty 3840", g_hi[0], 256);
        chk_eq("R4", "ch1 width duty 3600", g_hi[1], 16);
        chk_eq("R4", "ch2 no pulse duty == reload", g_hi[2], 0);
        chk_eq("R4", "ch3 width duty 4000", g_hi[3], 416);

        wr(2, 12'd3712);
        wait_irq(); measure();
        chk_eq("R5", "ch0 width unchanged without arm", g_hi[0], 256);

        wr(1, ctrl(1, 1, 4'hF, 4'h0));
        wait_irq(); measure();
        chk_eq("R5", "ch0 width after armed wrap", g_hi[0], 128);

        wr(2, 12'd4095);
        wait_irq(); measure();
        chk_eq("R6", "arm self-cleared, ch0 width kept", g_hi[0], 128);

        wr(1, ctrl(1, 1, 4'hF, 4'b0010));
        wait_irq(); measure();
        chk_eq("R7", "ch1 inverted width", g_hi[1], 496);
        chk_eq("R6", "ch0 copied duty 4095", g_hi[0], 511);

        wr(1, ctrl(1, 0, 4'b0101, 4'b0010));
        chk_eq("R8", "ch1 disabled at polarity level 1", int'(pwm_out[1]), 1);
        chk_eq("R8", "ch3 disabled at polarity level 0", int'(pwm_out[3]), 0);
        wait_irq(); measure();
        chk_eq("R8", "ch1 disabled whole period", g_hi[1], 512);
        chk_eq("R8", "ch3 disabled whole period", g_hi[3], 0);
        chk_eq("R8", "ch0 still enabled", g_hi[0], 511);

        wr(1, ctrl(0, 0, 4'b0101, 4'b0010));
        begin
            int seen = 0;
            for (int k = 0; k < 1100; k++) begin
                @(negedge clk);
                seen += int'(irq_pulse);
            end
            chk_eq("R9", "strobes while disabled", seen, 0);
        end

        wr(0, 12'd4000);
        wr(1, ctrl(1, 0, 4'b0101, 4'b0010));
        wait_irq(); measure();
        chk_eq("R3", "period with reload 4000", g_gap, 96);
        chk_eq("R4", "ch0 width at reload 4000", g_hi[0], 95);
        chk_eq("R4", "ch2 still no pulse", g_hi[2], 0);

        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_eq("R1", "pwm_out in second reset", int'(pwm_out), 0);
        chk_eq("R1", "irq in second reset", int'(irq_pulse), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk_eq("R1", "pwm_out after second reset", int'(pwm_out), 0);

        summary();
    end
endmodule